// File: doc/BRIEF.md
# Overcurrent Fault Supervisor with Clean-Cycle Hold

This block sits between two external overcurrent comparators and the gate-drive logic of a push-pull output stage. One comparator watches the high-side switch and the other watches the low-side switch. Each flag is brought into the clock domain through a two-stage synchronizer.

When a side trips, that side's kill output goes high and stays high for a fixed blanking time counted in clock cycles. A fresh trip while the blanking window is still open restarts the window. Downstream gate logic ANDs each gate with the inverse of its kill signal, so current is limited pulse by pulse.

A trip on either side also asserts a shared active-low fault flag, as long as the block is enabled and its control-path reset is released. The fault flag is released only when a run of complete switching cycles has passed with no trip. A switching cycle is marked by each rising edge of the cycle strobe. Driving the enable input low, or the control reset input low, releases the fault at once. The fault output is only ever a request to pull low or to let go, so the pad logic can wire several supervisors together.

Top module: `ocp_fault_supervisor`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `fault_n_o` is 1 and both kill outputs are 0.
- R2: Suppose `oc_hi_i` or `oc_lo_i` is sampled high at clock edge k while `en_i` and `ctl_rst_n_i` are high. Then `fault_n_o` reads 0 after edge k+2.
- R3: Suppose an overcurrent input is sampled high at edge k and was last sampled high at edge j. Its kill output reads 1 after edge k+2. It reads 0 again after edge j+2+OFF_CYC, where OFF_CYC defaults to 15.
- R4: A new trip arriving while a kill window is open restarts the window, so the kill stays high with no gap.
- R5: The two sides are independent. A high-side trip drives only `kill_hi_o`, and a low-side trip drives only `kill_lo_o`. Either side asserts the shared fault.
- R6: A strobe rising edge is an edge at which `cyc_strobe_i` is sampled 1 after being sampled 0 at the previous edge. Let j be the last edge at which a trip input was sampled high. The fault releases after the (HOLD_CYC+1)-th strobe rising edge that falls on an edge later than j+2. HOLD_CYC defaults to 4, so four complete clean cycles are required.
- R7: A trip while the fault is held restarts the clean-cycle count from zero.
- R8: When `en_i` is sampled 0, `fault_n_o` reads 1 after that same edge. Trips arriving while `en_i` is 0 do not assert the fault, but they still drive the kill outputs.
- R9: `ctl_rst_n_i` sampled 0 has the same effect on the fault as `en_i` sampled 0.
- R10: When `cyc_strobe_i` is held at 1, that counts as a single rising edge. The fault stays asserted while no further rising edge occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Block enable; 0 releases the fault at once |
| ctl_rst_n_i | input | 1 | Control-path reset, active low; 0 releases the fault at once |
| cyc_strobe_i | input | 1 | Active control input; each rising edge marks one switching cycle |
| oc_hi_i | input | 1 | High-side overcurrent comparator flag (asynchronous) |
| oc_lo_i | input | 1 | Low-side overcurrent comparator flag (asynchronous) |
| kill_hi_o | output | 1 | Forces the high-side gate off |
| kill_lo_o | output | 1 | Forces the low-side gate off |
| fault_n_o | output | 1 | Fault flag: 0 requests pull-low, 1 releases |

## Verification
The blanking counter can load or decrement wrongly. That shows as a kill edge that lands one or more cycles away from edge j+2+OFF_CYC, and it is visible within OFF_CYC+3 cycles of the trip.

The clean-cycle counter can count a strobe level instead of an edge, count the cycle in which a trip occurred, or fail to restart. Each of these moves the rising edge of `fault_n_o` by at least one strobe period.

If the enable or control-reset override is lost, `fault_n_o` stays low one cycle longer than it should, so the error shows on the very next clock.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  localparam int unsigned NUM_SIDES = 2;

  typedef enum logic [0:0] {
    SIDE_HI = 1'b0,
    SIDE_LO = 1'b1
  } side_e;

  typedef enum logic [1:0] {
    FLT_IDLE  = 2'd0,
    FLT_HELD  = 2'd1,
    FLT_FORCE = 2'd2
  } flt_act_e;
endpackage

// File: rtl/ocp_sync.sv
module ocp_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/ocp_blank_timer.sv
module ocp_blank_timer #(
  parameter int unsigned OFF_CYC = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic trip_i,
  output logic kill_o
);
  localparam int unsigned CW = $clog2(OFF_CYC + 1);
  localparam logic [CW-1:0] RELOAD = CW'(OFF_CYC - 1);

  logic [CW-1:0] remain_q;
  logic          kill_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q <= '0;
      kill_q   <= 1'b0;
    end else if (trip_i) begin
      remain_q <= RELOAD;
      kill_q   <= 1'b1;
    end else if (remain_q != '0) begin
      remain_q <= remain_q - 1'b1;
    end else begin
      kill_q <= 1'b0;
    end
  end

  assign kill_o = kill_q;
endmodule

// File: rtl/ocp_cycle_edge.sv
module ocp_cycle_edge (
  input  logic clk,
  input  logic rst,
  input  logic strobe_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= strobe_i;
  end

  assign rise_o = strobe_i & ~prev_q;
endmodule

// File: rtl/ocp_fault_hold.sv
module ocp_fault_hold
  import ocp_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic active_i,
  input  logic trip_i,
  input  logic cyc_rise_i,
  output logic fault_n_o
);
  localparam int unsigned HW = $clog2(HOLD_CYC + 1);
  localparam logic [HW-1:0] LAST = HW'(HOLD_CYC);

  logic          fault_q;
  logic [HW-1:0] clean_q;
  flt_act_e      act;

  always_comb begin
    if (!active_i)            act = FLT_IDLE;
    else if (trip_i)          act = FLT_FORCE;
    else if (fault_q)         act = FLT_HELD;
    else                      act = FLT_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_q <= 1'b0;
      clean_q <= '0;
    end else begin
      unique case (act)
        FLT_FORCE: begin
          fault_q <= 1'b1;
          clean_q <= '0;
        end
        FLT_HELD: begin
          if (cyc_rise_i) begin
            if (clean_q == LAST) begin
              fault_q <= 1'b0;
              clean_q <= '0;
            end else begin
              clean_q <= clean_q + 1'b1;
            end
          end
        end
        default: begin
          fault_q <= 1'b0;
          clean_q <= '0;
        end
      endcase
    end
  end

  assign fault_n_o = ~fault_q;
endmodule

// File: rtl/ocp_fault_supervisor.sv
module ocp_fault_supervisor
  import ocp_pkg::*;
#(
  parameter int unsigned OFF_CYC     = 15,
  parameter int unsigned HOLD_CYC    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic ctl_rst_n_i,
  input  logic cyc_strobe_i,
  input  logic oc_hi_i,
  input  logic oc_lo_i,
  output logic kill_hi_o,
  output logic kill_lo_o,
  output logic fault_n_o
);
  logic [NUM_SIDES-1:0] oc_raw;
  logic [NUM_SIDES-1:0] oc_sync;
  logic [NUM_SIDES-1:0] kill;
  logic                 cyc_rise;

  assign oc_raw[SIDE_HI] = oc_hi_i;
  assign oc_raw[SIDE_LO] = oc_lo_i;

  ocp_sync #(.WIDTH(NUM_SIDES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(oc_raw), .sync_o(oc_sync)
  );

  for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
    ocp_blank_timer #(.OFF_CYC(OFF_CYC)) u_blank (
      .clk(clk), .rst(rst), .trip_i(oc_sync[g]), .kill_o(kill[g])
    );
  end

  ocp_cycle_edge u_edge (
    .clk(clk), .rst(rst), .strobe_i(cyc_strobe_i), .rise_o(cyc_rise)
  );

  ocp_fault_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk(clk), .rst(rst),
    .active_i(en_i & ctl_rst_n_i),
    .trip_i(|oc_sync),
    .cyc_rise_i(cyc_rise),
    .fault_n_o(fault_n_o)
  );

  assign kill_hi_o = kill[SIDE_HI];
  assign kill_lo_o = kill[SIDE_LO];
endmodule

// File: rtl/ocp_fault_sva.sv
module ocp_fault_sva #(
  parameter int unsigned OFF_CYC     = 15,
  parameter int unsigned HOLD_CYC    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic clk,
  input logic rst,
  input logic en_i,
  input logic ctl_rst_n_i,
  input logic cyc_strobe_i,
  input logic oc_hi_i,
  input logic oc_lo_i,
  input logic kill_hi_o,
  input logic kill_lo_o,
  input logic fault_n_o
);
  int unsigned since_rst;
  int unsigned run_hi;
  int unsigned run_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_rst <= 0;
      run_hi    <= 0;
      run_lo    <= 0;
    end else begin
      if (since_rst < 8) since_rst <= since_rst + 1;
      run_hi <= kill_hi_o ? run_hi + 1 : 0;
      run_lo <= kill_lo_o ? run_lo + 1 : 0;
    end
  end

  // R8, R9: override releases the fault on the same edge
  assert_override_release_R8: assert property (@(posedge clk) disable iff (rst)
    (!en_i || !ctl_rst_n_i) |=> fault_n_o);

  // R2: a falling fault always comes with an active kill
  assert_fault_with_kill_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(fault_n_o) |-> (kill_hi_o || kill_lo_o));

  // R3: an input sampled high three edges back has its kill raised
  assert_kill_follows_hi_R3: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 4 && $past(oc_hi_i, 3)) |-> kill_hi_o);

  assert_kill_follows_lo_R3: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 4 && $past(oc_lo_i, 3)) |-> kill_lo_o);

  // R3: no kill window is shorter than the blanking time
  assert_kill_min_hi_R3: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2 && $fell(kill_hi_o)) |-> (run_hi >= OFF_CYC));

  assert_kill_min_lo_R3: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2 && $fell(kill_lo_o)) |-> (run_lo >= OFF_CYC));

  // R6: with the override inactive, release happens only on a strobe rise
  assert_release_on_rise_R6: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3 && $rose(fault_n_o) && $past(en_i) && $past(ctl_rst_n_i))
      |-> ($past(cyc_strobe_i) && !$past(cyc_strobe_i, 2)));
endmodule

bind ocp_fault_supervisor ocp_fault_sva #(
  .OFF_CYC(OFF_CYC), .HOLD_CYC(HOLD_CYC), .SYNC_STAGES(SYNC_STAGES)
) u_sva (.*);

// File: tb/tb_ocp_fault_supervisor.sv
module tb_ocp_fault_supervisor;
  localparam int OFF_CYC  = 15;
  localparam int HOLD_CYC = 4;

  logic clk = 1'b0;
  logic rst, en_i, ctl_rst_n_i, cyc_strobe_i, oc_hi_i, oc_lo_i;
  logic kill_hi_o, kill_lo_o, fault_n_o;

  int vectors = 0;
  int errors  = 0;
  string phase = "R1";

  always #2 clk = ~clk;

  ocp_fault_supervisor #(.OFF_CYC(OFF_CYC), .HOLD_CYC(HOLD_CYC)) dut (
    .clk(clk), .rst(rst), .en_i(en_i), .ctl_rst_n_i(ctl_rst_n_i),
    .cyc_strobe_i(cyc_strobe_i), .oc_hi_i(oc_hi_i), .oc_lo_i(oc_lo_i),
    .kill_hi_o(kill_hi_o), .kill_lo_o(kill_lo_o), .fault_n_o(fault_n_o)
  );

  // Behavioural reference model
  bit hist_hi[$];
  bit hist_lo[$];
  int left_hi, left_lo;
  bit m_kill_hi, m_kill_lo, m_fault, m_prev;
  int m_clean;

  always @(posedge clk) begin
    bit tr_hi, tr_lo, rise;
    if (rst) begin
      hist_hi = '{0, 0}; hist_lo = '{0, 0};
      left_hi = 0; left_lo = 0;
      m_kill_hi = 0; m_kill_lo = 0; m_fault = 0; m_prev = 0; m_clean = 0;
    end else begin
      tr_hi = hist_hi.pop_front(); hist_hi.push_back(oc_hi_i);
      tr_lo = hist_lo.pop_front(); hist_lo.push_back(oc_lo_i);
      if (tr_hi) begin m_kill_hi = 1; left_hi = OFF_CYC - 1; end
      else if (left_hi > 0) left_hi--;
      else m_kill_hi = 0;
      if (tr_lo) begin m_kill_lo = 1; left_lo = OFF_CYC - 1; end
      else if (left_lo > 0) left_lo--;
      else m_kill_lo = 0;
      rise = cyc_strobe_i && !m_prev;
      m_prev = cyc_strobe_i;
      if (!en_i || !ctl_rst_n_i) begin m_fault = 0; m_clean = 0; end
      else if (tr_hi || tr_lo) begin m_fault = 1; m_clean = 0; end
      else if (m_fault && rise) begin
        if (m_clean == HOLD_CYC) begin m_fault = 0; m_clean = 0; end
        else m_clean++;
      end
    end
  end

  task automatic check1(string what, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", phase, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    check1("kill_hi_o", kill_hi_o, m_kill_hi);
    check1("kill_lo_o", kill_lo_o, m_kill_lo);
    check1("fault_n_o", fault_n_o, !m_fault);
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic strobes(int n, int period);
    for (int i = 0; i < n; i++) begin
      cyc_strobe_i = 1'b1; step(period / 2);
      cyc_strobe_i = 1'b0; step(period - period / 2);
    end
  endtask

  task automatic expect_fault(string req, logic exp);
    vectors++;
    if (fault_n_o !== exp) begin
      errors++;
      $display("FAIL %s fault_n_o directed: actual %b expected %b", req, fault_n_o, exp);
    end
  endtask

  initial begin
    fork
      begin : stim
        rst = 1; en_i = 1; ctl_rst_n_i = 1; cyc_strobe_i = 0; oc_hi_i = 0; oc_lo_i = 0;
        step(4);
        expect_fault("R1", 1'b1);
        rst = 0; step(2);
        expect_fault("R1", 1'b1);

        phase = "R2"; // high-side single-cycle trip, then hold release (R3, R6)
        oc_hi_i = 1; step(1); oc_hi_i = 0; step(3);
        expect_fault("R2", 1'b0);
        phase = "R6"; strobes(6, 8); step(20);
        expect_fault("R6", 1'b1);

        phase = "R5"; // low side only
        oc_lo_i = 1; step(2); oc_lo_i = 0; step(20);
        strobes(6, 6); step(5);

        phase = "R4"; // retrigger inside the window
        oc_hi_i = 1; step(1); oc_hi_i = 0; step(8);
        oc_hi_i = 1; step(1); oc_hi_i = 0; step(25);

        phase = "R7"; // trip in the middle of the hold
        strobes(2, 8);
        oc_lo_i = 1; step(1); oc_lo_i = 0;
        strobes(3, 8);
        expect_fault("R7", 1'b0);
        strobes(3, 8); step(4);

        phase = "R10"; // strobe held high
        oc_hi_i = 1; step(1); oc_hi_i = 0; step(4);
        cyc_strobe_i = 1; step(40);
        expect_fault("R10", 1'b0);
        cyc_strobe_i = 0; strobes(6, 8);

        phase = "R8"; // enable override
        oc_hi_i = 1; step(1); oc_hi_i = 0; step(4);
        en_i = 0; step(1);
        expect_fault("R8", 1'b1);
        oc_lo_i = 1; step(2); oc_lo_i = 0; step(20);
        expect_fault("R8", 1'b1);
        en_i = 1; step(4);

        phase = "R9"; // control reset override
        oc_lo_i = 1; step(1); oc_lo_i = 0; step(4);
        ctl_rst_n_i = 0; step(1);
        expect_fault("R9", 1'b1);
        oc_hi_i = 1; step(1); oc_hi_i = 0; step(5);
        ctl_rst_n_i = 1; step(20);

        phase = "R5"; // both sides, staggered
        oc_hi_i = 1; step(3); oc_lo_i = 1; step(2); oc_hi_i = 0; step(4);
        oc_lo_i = 0; step(6); strobes(7, 10); step(10);
      end
      begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule